// File: doc/BRIEF.md
# Module power-state transition controller

This block moves one managed module between two power states, enabled and software-reset-disabled, under control of a small register bus. Software selects the wanted state in a control word, then starts the move with a separate command write. While the move is in flight a busy flag reads 1. The reported module state changes one cycle after busy clears, so software polls busy first and the state word second.

The block drives three outputs toward the managed module: a clock enable, an active-low module reset and an active-low local reset. When the module is disabled, its reset is held and its clock enable is off. On the way down the controller first waits for the module to report that it is idle, or for a bounded timeout. It then asserts the module reset and removes the clock two cycles later. On the way up it turns the clock on, lets it run for four cycles, and then releases the reset. The local reset is a separate software-owned bit. It can keep the module halted after it has been enabled, and no transition touches it.

Register map (word offsets on `addr`): 0x0 control (bit 0 target state, 1 = enabled; bit 1 local reset, active low); 0x1 command (bit 0 start); 0x2 transition status (bit 0 busy); 0x3 module status (bit 0 state, 1 = enabled). Every other bit, and every other offset, reads 0.

Top module: `modpwr_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `clk_en` = 0, `mod_rst_n` = 0 and `loc_rst_n` = 0, and the control (0x0), status (0x2) and module status (0x3) words all read 0. This holds for a reset applied in the middle of a transition as well.
- R2: A write to the control word (0x0) that changes only the target bit (bit 0) leaves `clk_en`, `mod_rst_n` and the module status word unchanged.
- R3: Writing 1 to bit 0 of the command word (0x1) when busy is 0 starts a transition toward the target bit and sets busy (bit 0 of 0x2). A command write while busy is 1 is ignored. The module state (bit 0 of 0x3) changes only when busy was already 0 in the previous cycle.
- R4: An enable transition sets `clk_en` in the cycle after the command write. It raises `mod_rst_n` and clears busy 4 cycles after that. It sets the module state bit one cycle after busy clears.
- R5: A disable transition with `idle_ack` high lowers `mod_rst_n` one cycle after the command write. It lowers `clk_en` and clears busy 2 cycles after that. It clears the module state bit one cycle after busy clears.
- R6: A disable transition with `idle_ack` held low keeps `mod_rst_n` high for 16 cycles after the command write and lowers it in the cycle after those 16.
- R7: A command write whose target equals the current module state keeps busy at 1 for exactly one cycle and changes no output.
- R8: Bit 1 of the control word drives `loc_rst_n` directly (0 = local reset asserted) from the cycle after the write. It reads back as written, and no transition changes it.
- R9: Read data appears on `rdata` in the cycle after `rd_en` is sampled and is held until the next read. The command word and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| idle_ack | input | 1 | Module reports it is idle and may be stopped |
| clk_en | output | 1 | Clock enable for the managed module |
| mod_rst_n | output | 1 | Module reset, active low |
| loc_rst_n | output | 1 | Local reset, active low, software owned |

## Verification
On every cycle the assertions check the ordering rules. The reset always covers the clock edges where the clock starts or stops. Busy rises only after a command write. The state bit moves only after a cycle without busy. Outside a transition the outputs match the reported state. The two control bits change only on a write to the control word. The exact cycle counts can only be shown by the bench's timed scenarios: the four-cycle warm-up, the two-cycle hold before the clock stops, the sixteen-cycle timeout, the one-cycle no-change command, and the dropped command during a transition. The same applies to the read-back values and the effect of a reset in the middle of a transition.

// File: rtl/modpwr_pkg.sv
package modpwr_pkg;

   // Register word offsets
   localparam int OFS_CTRL  = 0;
   localparam int OFS_CMD   = 1;
   localparam int OFS_STAT  = 2;
   localparam int OFS_MSTAT = 3;

   // Field positions
   localparam int CTRL_TGT_BIT   = 0;
   localparam int CTRL_LRST_BIT  = 1;
   localparam int CMD_START_BIT  = 0;
   localparam int STAT_BUSY_BIT  = 0;
   localparam int MSTAT_ON_BIT   = 0;

   localparam int FIELD_MSB = 1;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_NOP,
      SQ_QUIESCE,
      SQ_HOLD,
      SQ_WARM
   } seq_st_e;

endpackage

// File: rtl/modpwr_regs.sv
module modpwr_regs
   import modpwr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              tgt_on,
   output logic              lrst_n,
   output logic              start_req
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);

   if (DATA_W <= FIELD_MSB) begin : g_bad_dw
      $error("modpwr_regs: DATA_W too small for the control fields");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("modpwr_regs: ADDR_W must cover four words");
   end

   logic ctrl_wr;
   logic unused_wbits;

   assign ctrl_wr      = wr_en && (addr == A_CTRL);
   assign start_req    = wr_en && (addr == A_CMD) && wdata[CMD_START_BIT];
   assign unused_wbits = ^wdata[DATA_W-1:FIELD_MSB+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_on <= 1'b0;
         lrst_n <= 1'b0;
      end else if (ctrl_wr) begin
         tgt_on <= wdata[CTRL_TGT_BIT];
         lrst_n <= wdata[CTRL_LRST_BIT];
      end
   end

   // R8: local reset bit moves only on a control write
   p_lrst_sw_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lrst_n) |-> $past(wr_en && (addr == A_CTRL)))
      else $error("local reset bit changed without a control write");

   // R2: target bit moves only on a control write
   p_tgt_sw_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tgt_on) |-> $past(wr_en && (addr == A_CTRL)))
      else $error("target bit changed without a control write");

endmodule

// File: rtl/modpwr_seq.sv
module modpwr_seq
   import modpwr_pkg::*;
#(
   parameter int IDLE_TMO = 16,
   parameter int OFF_DLY  = 2,
   parameter int WARM_DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic tgt_on,
   input  logic idle_ack,
   output logic busy,
   output logic clk_en,
   output logic mod_rst_n,
   output logic state_on
);

   localparam int MAX_A   = (IDLE_TMO > OFF_DLY) ? IDLE_TMO : OFF_DLY;
   localparam int MAX_DLY = (MAX_A > WARM_DLY) ? MAX_A : WARM_DLY;
   localparam int CNT_W   = $clog2(MAX_DLY + 1);
   localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(IDLE_TMO - 1);
   localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(OFF_DLY - 1);
   localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_DLY - 1);

   if (IDLE_TMO < 1 || OFF_DLY < 1 || WARM_DLY < 1) begin : g_bad_dly
      $error("modpwr_seq: every delay must be at least one cycle");
   end

   seq_st_e          sq;
   logic [CNT_W-1:0] cnt;
   logic             upd_pend;
   logic             upd_val;
   logic             eff_on;

   // State the module is headed to once the pending update lands
   assign eff_on = upd_pend ? upd_val : state_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq        <= SQ_IDLE;
         cnt       <= '0;
         busy      <= 1'b0;
         clk_en    <= 1'b0;
         mod_rst_n <= 1'b0;
         state_on  <= 1'b0;
         upd_pend  <= 1'b0;
         upd_val   <= 1'b0;
      end else begin
         upd_pend <= 1'b0;
         if (upd_pend) state_on <= upd_val;
         unique case (sq)
            SQ_IDLE: begin
               if (start_req) begin
                  busy <= 1'b1;
                  cnt  <= '0;
                  if (tgt_on == eff_on) begin
                     sq <= SQ_NOP;
                  end else if (tgt_on) begin
                     clk_en <= 1'b1;
                     sq     <= SQ_WARM;
                  end else begin
                     sq <= SQ_QUIESCE;
                  end
               end
            end
            SQ_NOP: begin
               busy <= 1'b0;
               sq   <= SQ_IDLE;
            end
            SQ_QUIESCE: begin
               if (idle_ack || cnt == TMO_LAST) begin
                  mod_rst_n <= 1'b0;
                  cnt       <= '0;
                  sq        <= SQ_HOLD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQ_HOLD: begin
               if (cnt == OFF_LAST) begin
                  clk_en   <= 1'b0;
                  busy     <= 1'b0;
                  upd_pend <= 1'b1;
                  upd_val  <= 1'b0;
                  sq       <= SQ_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQ_WARM: begin
               if (cnt == WARM_LAST) begin
                  mod_rst_n <= 1'b1;
                  busy      <= 1'b0;
                  upd_pend  <= 1'b1;
                  upd_val   <= 1'b1;
                  sq        <= SQ_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: sq <= SQ_IDLE;
         endcase
      end
   end

   // R3: busy is raised only by a start request
   p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_req))
      else $error("busy rose without a start request");

   // R3: reported state moves only after a cycle without busy
   p_state_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state_on) |-> $past(!busy))
      else $error("state changed while busy was still set");

   // R1: settled disabled state keeps reset held and clock off
   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !upd_pend && !state_on) |-> (!clk_en && !mod_rst_n))
      else $error("disabled module has clock or reset released");

   // R4: settled enabled state keeps clock on and reset released
   p_on_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !upd_pend && state_on) |-> (clk_en && mod_rst_n))
      else $error("enabled module lacks clock or reset release");

   // R4: reset is released only into a running clock
   p_rel_after_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_rst_n) |-> (clk_en && $past(clk_en)))
      else $error("reset released without a running clock");

   // R5: clock stops only under an already held reset
   p_clk_off_in_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> (!mod_rst_n && $past(!mod_rst_n)))
      else $error("clock stopped before reset was held");

   // R7: a no-change start keeps busy for one cycle only
   p_nop_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sq == SQ_NOP) |=> !busy)
      else $error("no-change start held busy too long");

endmodule

// File: rtl/modpwr_rdport.sv
module modpwr_rdport
   import modpwr_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              tgt_on,
   input  logic              lrst_n,
   input  logic              busy,
   input  logic              state_on,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(OFS_MSTAT);

   logic [DATA_W-1:0] word;

   always_comb begin
      word = '0;
      if (addr == A_CTRL) begin
         word[CTRL_TGT_BIT]  = tgt_on;
         word[CTRL_LRST_BIT] = lrst_n;
      end else if (addr == A_STAT) begin
         word[STAT_BUSY_BIT] = busy;
      end else if (addr == A_MSTAT) begin
         word[MSTAT_ON_BIT] = state_on;
      end
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata <= '0;
         else if (rd_en) rdata <= word;
      end

      // R9: read data is held between reads
      p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(rd_en) |-> $stable(rdata))
         else $error("read data moved without a read");

      // R9: the command word reads as zero
      p_cmd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rd_en && addr == A_CMD) |-> (rdata == '0))
         else $error("command word read back nonzero");
   end else begin : g_rd_comb
      logic unused_rdctl;
      assign unused_rdctl = clk ^ rst_n ^ rd_en;
      assign rdata = word;
   end

endmodule

// File: rtl/modpwr_ctrl.sv
module modpwr_ctrl
   import modpwr_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter int IDLE_TMO = 16,
   parameter int OFF_DLY  = 2,
   parameter int WARM_DLY = 4,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              idle_ack,
   output logic              clk_en,
   output logic              mod_rst_n,
   output logic              loc_rst_n
);

   logic tgt_on;
   logic lrst_n;
   logic start_req;
   logic busy;
   logic state_on;

   modpwr_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .tgt_on    (tgt_on),
      .lrst_n    (lrst_n),
      .start_req (start_req)
   );

   modpwr_seq #(
      .IDLE_TMO (IDLE_TMO),
      .OFF_DLY  (OFF_DLY),
      .WARM_DLY (WARM_DLY)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .tgt_on    (tgt_on),
      .idle_ack  (idle_ack),
      .busy      (busy),
      .clk_en    (clk_en),
      .mod_rst_n (mod_rst_n),
      .state_on  (state_on)
   );

   modpwr_rdport #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .READ_REG (READ_REG)
   ) rdport_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .addr     (addr),
      .tgt_on   (tgt_on),
      .lrst_n   (lrst_n),
      .busy     (busy),
      .state_on (state_on),
      .rdata    (rdata)
   );

   assign loc_rst_n = lrst_n;

endmodule

// File: tb/modpwr_ctrl_tb_top.sv
module modpwr_ctrl_tb_top;

   localparam logic [3:0] A_CTRL = 4'h0, A_CMD = 4'h1, A_STAT = 4'h2, A_MST = 4'h3;
   localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_P = 2'd2, OP_I = 2'd3;
   localparam int NV = 21;

   // {op, addr, data}; for OP_P data is {loc_rst_n, mod_rst_n, clk_en}
   localparam logic [37:0] VEC [NV] = '{
      {OP_R, A_CTRL, 32'h0}, {OP_R, A_STAT, 32'h0}, {OP_R, A_MST, 32'h0},
      {OP_P, 4'h0, 32'h0},
      {OP_W, A_CTRL, 32'h1}, {OP_P, 4'h0, 32'h0}, {OP_R, A_MST, 32'h0},
      {OP_R, A_CTRL, 32'h1},
      {OP_W, A_CTRL, 32'h3}, {OP_P, 4'h0, 32'h4}, {OP_R, A_CTRL, 32'h3},
      {OP_R, A_CMD, 32'h0}, {OP_R, 4'h7, 32'h0},
      {OP_W, A_CTRL, 32'h1}, {OP_P, 4'h0, 32'h0}, {OP_W, A_CTRL, 32'h3},
      {OP_W, A_CMD, 32'h1}, {OP_I, 4'h0, 32'd8},
      {OP_R, A_STAT, 32'h0}, {OP_R, A_MST, 32'h1}, {OP_P, 4'h0, 32'h7}
   };
   string vtag [NV] = '{
      "R1", "R1", "R1", "R1",
      "R2", "R2", "R2", "R2",
      "R8", "R8", "R8", "R9", "R9",
      "R8", "R8", "R8",
      "R4", "R4", "R4", "R4", "R4"
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        idle_ack = 1'b0;
   logic        clk_en, mod_rst_n, loc_rst_n;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   modpwr_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .idle_ack  (idle_ack),
      .clk_en    (clk_en),
      .mod_rst_n (mod_rst_n),
      .loc_rst_n (loc_rst_n)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] pins();
      return {29'b0, loc_rst_n, mod_rst_n, clk_en};
   endfunction

   task automatic rchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int hi_miss;
      step();
      chk("R1", pins(), 32'h0);          // outputs held while in reset
      step();
      rst_n = 1'b1;
      step();

      // Table walk
      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [3:0]  a;
         logic [31:0] v;
         op = VEC[i][37:36];
         a  = VEC[i][35:32];
         v  = VEC[i][31:0];
         case (op)
            OP_W: wr(a, v);
            OP_R: begin rd(a, d); chk(vtag[i], d, v); end
            OP_P: chk(vtag[i], pins(), v);
            default: repeat (v) step();
         endcase
      end

      // R7: start with target equal to state (enabled, target 1)
      wr(A_CMD, 32'h1);
      rchk("R7", A_STAT, 32'h1);
      rchk("R7", A_STAT, 32'h0);
      chk("R7", pins(), 32'h7);
      rchk("R7", A_MST, 32'h1);

      // R5: disable with idle acknowledge already high
      idle_ack = 1'b1;
      wr(A_CTRL, 32'h2);
      wr(A_CMD, 32'h1);                  // t0
      chk("R5", pins(), 32'h7);
      rchk("R5", A_STAT, 32'h1);         // now t1
      chk("R5", pins(), 32'h5);
      step();                             // t2
      chk("R5", pins(), 32'h5);
      rchk("R5", A_STAT, 32'h1);         // now t3
      chk("R5", pins(), 32'h4);
      rchk("R5", A_MST, 32'h1);          // state still lags at t3
      rchk("R5", A_MST, 32'h0);
      rchk("R5", A_STAT, 32'h0);
      idle_ack = 1'b0;

      // R4 and R3: enable, with a second start while busy
      wr(A_CTRL, 32'h3);
      wr(A_CMD, 32'h1);                  // t0
      chk("R4", pins(), 32'h5);
      wr(A_CTRL, 32'h2);                 // target back to off, now t1
      chk("R4", pins(), 32'h5);
      wr(A_CMD, 32'h1);                  // ignored start, now t2
      chk("R3", pins(), 32'h5);
      step();                             // t3
      chk("R4", pins(), 32'h5);
      step();                             // t4
      chk("R4", pins(), 32'h7);
      rchk("R4", A_STAT, 32'h0);         // busy cleared at t4
      rchk("R4", A_MST, 32'h1);
      repeat (6) step();
      chk("R3", pins(), 32'h7);          // ignored start did not disable
      rchk("R3", A_STAT, 32'h0);
      rchk("R3", A_MST, 32'h1);
      rchk("R8", A_CTRL, 32'h2);

      // R6: disable with no idle acknowledge, timeout path
      hi_miss = 0;
      wr(A_CMD, 32'h1);                  // t0
      for (int k = 0; k < 16; k++) begin
         if (mod_rst_n !== 1'b1) hi_miss++;
         step();
      end                                 // now t16
      chk("R6", 32'(hi_miss), 32'h0);
      chk("R6", pins(), 32'h5);
      step(); step();                     // t18
      chk("R6", pins(), 32'h4);
      rchk("R6", A_STAT, 32'h0);
      rchk("R6", A_MST, 32'h0);
      chk("R8", 32'(loc_rst_n), 32'h1);

      // R1: reset in the middle of an enable transition
      wr(A_CTRL, 32'h3);
      wr(A_CMD, 32'h1);
      step();
      rst_n = 1'b0;
      step();
      chk("R1", pins(), 32'h0);
      rst_n = 1'b1;
      step();
      rchk("R1", A_CTRL, 32'h0);
      rchk("R1", A_STAT, 32'h0);
      rchk("R1", A_MST, 32'h0);
      chk("R1", pins(), 32'h0);

      // R9: read data held with no read in flight
      d = rdata;
      wr(A_CTRL, 32'h3);
      step();
      chk("R9", rdata, d);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule